// File: doc/BRIEF.md
# Answer-to-Reset Timing Supervisor

This block supervises the timing of a contact card's answer to reset. It sees the level of the card reset line. When that line rises from low to high, it counts card clocks until the receiver reports the leading edge of the first character. That edge must land inside a fixed window of clock counts. After the first edge, the block counts ETU ticks. One counter measures the gap since the most recent character leading edge, which is the per-character waiting time. A second counter measures the time since the first edge, which is an optional cap on the whole answer.

Each window has its own reference point. The supervisor raises a sticky flag when a window is violated. It reports the end of the answer on time grounds when the waiting time runs out, or when the total cap is reached. It also records whether the current reset was the first since power-up, so that the surrounding logic can tell a cold answer from a warm one. Character decoding and content parsing belong to other blocks.

Top module: `atr_timing_watch`

## Requirements
- R1: A session starts only on a low-to-high transition of `card_rst_lvl` sampled by the block. A level that is already high when the block reset `rst` is released starts nothing, so leading edges seen then raise no flag.
- R2: If the first `lead_edge` is sampled fewer than `MIN_CLK` (400) clocks after the clock edge that detected the reset release, `too_early` goes to 1 and the session ends.
- R3: If no `lead_edge` arrives by `MAX_CLK` (40000) clocks after the release, `no_answer` goes to 1 on the clock edge that completes the count. A first edge sampled at exactly 40000 clocks is accepted.
- R4: After the first edge, `wait_expired` goes to 1 once `WT_STD` (9600) ETU ticks pass with no `lead_edge`. Each `lead_edge` restarts this count. A `lead_edge` sampled together with the tick that would expire the count cancels the expiry.
- R5: When extended limits are selected for the session, the waiting-time limit is `WT_EXT` (10800) ETU ticks instead of 9600.
- R6: With extended limits only, `span_expired` goes to 1 once `SPAN_ETU` (20160) ETU ticks have elapsed since the first edge, whatever later edges occur. With standard limits it never rises.
- R7: While `card_rst_lvl` is low, all four flags and all counters clear. The flags read 0 from the clock edge after the low level is sampled.
- R8: `pwr_cold` and `ext_limits` are sampled on the release edge only. `cold_session` shows the sampled `pwr_cold` until the next release, and changes to `ext_limits` during a session have no effect.
- R9: Once any flag is set, the session has ended. Further leading edges and ticks change no flag until `card_rst_lvl` goes low.
- R10: ETU ticks that arrive before the first accepted leading edge are not counted in the waiting time or the total cap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous active-high block reset |
| card_rst_lvl | input | 1 | Level of the card reset line (1 = released) |
| lead_edge | input | 1 | One-cycle strobe: receiver saw a character leading edge |
| etu_tick | input | 1 | One-cycle strobe per elapsed ETU |
| pwr_cold | input | 1 | 1 when this reset is the first since power-up |
| ext_limits | input | 1 | Selects the extended waiting time and the total cap |
| too_early | output | 1 | First edge came before the minimum clock count |
| no_answer | output | 1 | No first edge within the maximum clock count |
| wait_expired | output | 1 | Gap between leading edges reached the waiting-time limit |
| span_expired | output | 1 | Total answer duration reached the cap |
| cold_session | output | 1 | Sampled cold/warm indicator for the current session |

## Verification
The bench aims at the exact boundaries of each window.

- **First-character window.** An edge at 399 clocks must be rejected and one at 400 accepted. An off-by-one counter shifts the clock edge on which the flag appears.
- **Late first edge.** An edge at exactly 40000 clocks must pass, while silence must flag on that same edge. A design that tests with a strict comparison would reject the edge or flag one cycle late.
- **Edge on the expiring tick.** A strobe sampled on the tick that would expire the waiting time must win. A design that gives priority to the tick would end the answer early.
- **Cap reference point.** Strobes must not restart the total cap. A design that reuses the waiting-time reference would never raise `span_expired`.
- **Mode sampling.** A mode change made in mid-session must be ignored. A design that reads the live input would shorten the extended limit.

// File: rtl/atr_sup_pkg.sv
package atr_sup_pkg;

    typedef enum logic [1:0] {
        SUP_IDLE,
        SUP_FIRST,
        SUP_ANSWER,
        SUP_ENDED
    } sup_state_e;

    typedef struct packed {
        logic early;
        logic silent;
        logic wait_out;
        logic span_out;
    } sup_flags_t;

    // bits needed to hold values 0..maxv
    function automatic int unsigned cnt_width(input int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/atr_release_latch.sv
module atr_release_latch (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic cold_in,
    input  logic ext_in,
    output logic release_p,
    output logic lvl_q,
    output logic cold_q,
    output logic ext_q
);
    // lvl_q resets high: a line already high at block reset is not a release
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= 1'b1;
            cold_q <= 1'b0;
            ext_q  <= 1'b0;
        end else begin
            lvl_q <= lvl;
            if (release_p) begin
                cold_q <= cold_in;
                ext_q  <= ext_in;
            end
        end
    end

    assign release_p = lvl & ~lvl_q;

endmodule

// File: rtl/atr_first_window.sv
module atr_first_window #(
    parameter int unsigned MIN_CLK = 400,
    parameter int unsigned MAX_CLK = 40000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic start,
    input  logic run,
    input  logic strobe,
    output logic early,
    output logic late,
    output logic accept
);
    localparam int unsigned CW = atr_sup_pkg::cnt_width(MAX_CLK);

    logic [CW-1:0] clk_cnt;

    // clk_cnt holds the clocks elapsed since the release-detecting edge
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            clk_cnt <= '0;
        end else if (start) begin
            clk_cnt <= CW'(1);
        end else if (run && !strobe && clk_cnt != CW'(MAX_CLK)) begin
            clk_cnt <= clk_cnt + 1'b1;
        end
    end

    assign early  = run &  strobe & (clk_cnt <  CW'(MIN_CLK));
    assign accept = run &  strobe & (clk_cnt >= CW'(MIN_CLK));
    assign late   = run & ~strobe & (clk_cnt == CW'(MAX_CLK));

endmodule

// File: rtl/atr_etu_windows.sv
module atr_etu_windows #(
    parameter int unsigned WT_STD   = 9600,
    parameter int unsigned WT_EXT   = 10800,
    parameter int unsigned SPAN_ETU = 20160
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic start,
    input  logic run,
    input  logic tick,
    input  logic strobe,
    input  logic ext,
    output logic wt_hit,
    output logic span_hit
);
    localparam int unsigned TOPV = atr_sup_pkg::max3(WT_STD, WT_EXT, SPAN_ETU);
    localparam int unsigned EW   = atr_sup_pkg::cnt_width(TOPV);

    logic [EW-1:0] wt_cnt;
    logic [EW-1:0] wt_lim;

    assign wt_lim = ext ? EW'(WT_EXT - 1) : EW'(WT_STD - 1);

    // gap since the most recent leading edge; a strobe beats a tick
    always_ff @(posedge clk) begin
        if (rst || clear || start) begin
            wt_cnt <= '0;
        end else if (run) begin
            if (strobe)
                wt_cnt <= '0;
            else if (tick)
                wt_cnt <= wt_cnt + 1'b1;
        end
    end

    assign wt_hit = run & tick & ~strobe & (wt_cnt == wt_lim);

    generate
        if (SPAN_ETU > 0) begin : g_span
            logic [EW-1:0] span_cnt;

            // duration since the first edge; later strobes do not touch it
            always_ff @(posedge clk) begin
                if (rst || clear || start)
                    span_cnt <= '0;
                else if (run && tick)
                    span_cnt <= span_cnt + 1'b1;
            end

            assign span_hit = run & ext & tick & (span_cnt == EW'(SPAN_ETU - 1));
        end else begin : g_nospan
            assign span_hit = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/atr_timing_watch.sv
module atr_timing_watch #(
    parameter int unsigned MIN_CLK  = 400,
    parameter int unsigned MAX_CLK  = 40000,
    parameter int unsigned WT_STD   = 9600,
    parameter int unsigned WT_EXT   = 10800,
    parameter int unsigned SPAN_ETU = 20160
) (
    input  logic clk,
    input  logic rst,
    input  logic card_rst_lvl,
    input  logic lead_edge,
    input  logic etu_tick,
    input  logic pwr_cold,
    input  logic ext_limits,
    output logic too_early,
    output logic no_answer,
    output logic wait_expired,
    output logic span_expired,
    output logic cold_session
);
    import atr_sup_pkg::*;

    sup_state_e st;
    sup_flags_t fl;

    logic release_p, lvl_q, cold_q, ext_q;
    logic early, late, accept;
    logic wt_hit, span_hit;
    logic line_low;

    assign line_low = ~card_rst_lvl;

    atr_release_latch u_rel (
        .clk       (clk),
        .rst       (rst),
        .lvl       (card_rst_lvl),
        .cold_in   (pwr_cold),
        .ext_in    (ext_limits),
        .release_p (release_p),
        .lvl_q     (lvl_q),
        .cold_q    (cold_q),
        .ext_q     (ext_q)
    );

    atr_first_window #(
        .MIN_CLK (MIN_CLK),
        .MAX_CLK (MAX_CLK)
    ) u_first (
        .clk    (clk),
        .rst    (rst),
        .clear  (line_low),
        .start  (release_p),
        .run    (st == SUP_FIRST),
        .strobe (lead_edge),
        .early  (early),
        .late   (late),
        .accept (accept)
    );

    atr_etu_windows #(
        .WT_STD   (WT_STD),
        .WT_EXT   (WT_EXT),
        .SPAN_ETU (SPAN_ETU)
    ) u_etu (
        .clk      (clk),
        .rst      (rst),
        .clear    (line_low),
        .start    (accept),
        .run      (st == SUP_ANSWER),
        .tick     (etu_tick),
        .strobe   (lead_edge),
        .ext      (ext_q),
        .wt_hit   (wt_hit),
        .span_hit (span_hit)
    );

    always_ff @(posedge clk) begin
        if (rst || line_low) begin
            st <= SUP_IDLE;
            fl <= '0;
        end else if (release_p) begin
            st <= SUP_FIRST;
            fl <= '0;
        end else begin
            case (st)
                SUP_FIRST: begin
                    if (early) begin
                        fl.early <= 1'b1;
                        st       <= SUP_ENDED;
                    end else if (late) begin
                        fl.silent <= 1'b1;
                        st        <= SUP_ENDED;
                    end else if (accept) begin
                        st <= SUP_ANSWER;
                    end
                end
                SUP_ANSWER: begin
                    if (wt_hit)
                        fl.wait_out <= 1'b1;
                    if (span_hit)
                        fl.span_out <= 1'b1;
                    if (wt_hit || span_hit)
                        st <= SUP_ENDED;
                end
                default: ;
            endcase
        end
    end

    assign too_early    = fl.early;
    assign no_answer    = fl.silent;
    assign wait_expired = fl.wait_out;
    assign span_expired = fl.span_out;
    assign cold_session = cold_q;

endmodule

// File: rtl/atr_timing_watch_chk.sv
module atr_timing_watch_chk (
    input logic clk,
    input logic rst,
    input logic card_rst_lvl,
    input logic too_early,
    input logic no_answer,
    input logic wait_expired,
    input logic span_expired,
    input logic cold_session,
    input logic lvl_q,
    input logic ext_q
);
    // R7
    low_line_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !card_rst_lvl |=> !(too_early || no_answer || wait_expired || span_expired));

    // R9
    early_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        too_early && card_rst_lvl |=> too_early);

    // R2
    first_outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(too_early && no_answer));

    // R4
    wait_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        wait_expired |-> !too_early && !no_answer);

    // R6
    span_needs_ext_chk: assert property (@(posedge clk) disable iff (rst)
        span_expired |-> ext_q);

    // R8
    cold_hold_chk: assert property (@(posedge clk) disable iff (rst)
        card_rst_lvl && lvl_q |=> $stable(cold_session));

endmodule

bind atr_timing_watch atr_timing_watch_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .card_rst_lvl (card_rst_lvl),
    .too_early    (too_early),
    .no_answer    (no_answer),
    .wait_expired (wait_expired),
    .span_expired (span_expired),
    .cold_session (cold_session),
    .lvl_q        (lvl_q),
    .ext_q        (ext_q)
);

// File: tb/atr_timing_watch_tb.sv
module atr_timing_watch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCH_CYC  = 195000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic card_rst_lvl = 1'b1;
    logic lead_edge = 1'b0;
    logic etu_tick = 1'b1;
    logic pwr_cold = 1'b0;
    logic ext_limits = 1'b0;
    logic too_early, no_answer, wait_expired, span_expired, cold_session;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    atr_timing_watch u_dut (
        .clk          (clk),
        .rst          (rst),
        .card_rst_lvl (card_rst_lvl),
        .lead_edge    (lead_edge),
        .etu_tick     (etu_tick),
        .pwr_cold     (pwr_cold),
        .ext_limits   (ext_limits),
        .too_early    (too_early),
        .no_answer    (no_answer),
        .wait_expired (wait_expired),
        .span_expired (span_expired),
        .cold_session (cold_session)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_now();
        lead_edge = 1'b1;
        @(negedge clk);
        lead_edge = 1'b0;
    endtask

    // pulls the line low, then releases it; returns on the releasing negedge
    task automatic release_card(input logic cold, input logic ext);
        card_rst_lvl = 1'b0;
        wait_cyc(2);
        pwr_cold     = cold;
        ext_limits   = ext;
        card_rst_lvl = 1'b1;
    endtask

    task automatic first_edge(input int d);
        wait_cyc(d);
        strobe_now();
    endtask

    task automatic t_reset_state();
        chk("R7 reset too_early", too_early, 1'b0);
        chk("R7 reset no_answer", no_answer, 1'b0);
        chk("R7 reset wait_expired", wait_expired, 1'b0);
        chk("R7 reset span_expired", span_expired, 1'b0);
        chk("R8 reset cold_session", cold_session, 1'b0);
    endtask

    task automatic t_no_release();
        wait_cyc(20);
        strobe_now();
        wait_cyc(5);
        chk("R1 high line at reset starts nothing", too_early, 1'b0);
        chk("R1 no_answer idle", no_answer, 1'b0);
    endtask

    task automatic t_too_early();
        release_card(1'b1, 1'b0);
        first_edge(399);
        chk("R2 edge at 399 clocks", too_early, 1'b1);
        chk("R2 no_answer stays low", no_answer, 1'b0);
        strobe_now();
        wait_cyc(50);
        chk("R9 ended: too_early held", too_early, 1'b1);
        chk("R9 ended: no wait flag", wait_expired, 1'b0);
        card_rst_lvl = 1'b0;
        wait_cyc(1);
        chk("R7 low line clears too_early", too_early, 1'b0);
    endtask

    task automatic t_no_answer();
        release_card(1'b1, 1'b0);
        wait_cyc(40000);
        chk("R3 no flag before limit", no_answer, 1'b0);
        wait_cyc(1);
        chk("R3 silent at 40000", no_answer, 1'b1);
        release_card(1'b1, 1'b0);
        first_edge(40000);
        chk("R3 edge at exactly 40000 accepted", no_answer, 1'b0);
        chk("R3 edge at 40000 not early", too_early, 1'b0);
    endtask

    task automatic t_ext_wait();
        release_card(1'b0, 1'b1);
        first_edge(400);
        chk("R2 edge at 400 accepted", too_early, 1'b0);
        chk("R8 warm session", cold_session, 1'b0);
        ext_limits = 1'b0;
        wait_cyc(9600);
        chk("R5 no expiry at 9600 in extended mode", wait_expired, 1'b0);
        chk("R8 ext change ignored", wait_expired, 1'b0);
        wait_cyc(1199);
        chk("R5 no expiry at 10799", wait_expired, 1'b0);
        wait_cyc(1);
        chk("R5 expiry at 10800", wait_expired, 1'b1);
    endtask

    task automatic t_span_cap();
        release_card(1'b1, 1'b1);
        first_edge(400);
        chk("R8 cold session", cold_session, 1'b1);
        for (int i = 0; i < 4; i++) begin
            wait_cyc(4999);
            strobe_now();
        end
        wait_cyc(159);
        chk("R6 no cap at 20159", span_expired, 1'b0);
        wait_cyc(1);
        chk("R6 cap at 20160", span_expired, 1'b1);
        chk("R6 cap not a wait expiry", wait_expired, 1'b0);
        card_rst_lvl = 1'b0;
        wait_cyc(1);
        chk("R7 low line clears span", span_expired, 1'b0);
    endtask

    task automatic t_std_nocap();
        release_card(1'b0, 1'b0);
        first_edge(400);
        for (int i = 0; i < 4; i++) begin
            wait_cyc(4999);
            strobe_now();
        end
        wait_cyc(160);
        chk("R6 no cap in standard mode", span_expired, 1'b0);
        chk("R4 strobes keep wait alive", wait_expired, 1'b0);
        wait_cyc(9439);
        chk("R4 no expiry at 9599 after last edge", wait_expired, 1'b0);
        wait_cyc(1);
        chk("R4 expiry 9600 after last edge", wait_expired, 1'b1);
    endtask

    task automatic t_edge_on_expiry();
        release_card(1'b1, 1'b0);
        first_edge(400);
        wait_cyc(9599);
        strobe_now();
        chk("R4 edge on expiring tick wins", wait_expired, 1'b0);
        wait_cyc(9599);
        chk("R10 no expiry at 9599 after cancel", wait_expired, 1'b0);
        wait_cyc(1);
        chk("R4 expiry after cancel", wait_expired, 1'b1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        wait_cyc(3);
        t_reset_state();
        rst = 1'b0;
        t_no_release();
        t_too_early();
        t_no_answer();
        t_ext_wait();
        t_span_cap();
        t_std_nocap();
        t_edge_on_expiry();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (WATCH_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

endmodule